// File: doc/BRIEF.md
# SMBus Indexed Block-Access Register Slave

This block is an SMBus target that keeps a small bank of 8-bit control registers and presents every register bit to the surrounding output-control logic. It runs on a fast system clock. SCL and SDA are treated as ordinary inputs that are resampled by that clock. SDA is driven open-drain: the block only ever pulls the line low, through a single drive-low output.

The host reaches the bank with two transfer types, and both begin with a start index. A block write carries the target address with the write bit, a start index, a byte count and then the data. The data lands at consecutive indices, and every byte is acknowledged. A block read first sets the index through a short write phase. It then issues a repeated start and the address with the read bit. The block answers with the contents of its byte-count register, followed by the registers from the start index upward. This continues until the host refuses a byte.

The bank has seven locations. Location 0 holds mode bits and location 1 holds per-output enables. Location 2 holds per-output stoppable flags and location 3 is spare storage. Location 4 is a read-only identifier, location 5 a writable device identifier and location 6 the byte count returned on reads.

Top module: `smb_regbank_slave`

## Requirements
- R1: The block answers only the 7-bit address 0x6E (address bytes 0xDC for write, 0xDD for read, R/W in bit 0). Any other address byte is left unacknowledged, and the rest of that transfer, up to the next start condition, is ignored.
- R2: In a block write (start, 0xDC, index N, count X, X data bytes, stop), each data byte is stored at N, N+1, … N+X-1, and every byte of the transfer is acknowledged.
- R3: Data bytes sent after the X announced by the count are acknowledged and discarded.
- R4: In a block read (start, 0xDC, index N, repeated start, 0xDD), the first byte returned is the current value of register 6. After it come the registers from index N upward, one per host acknowledge. A NACK from the host ends the transfer, and SDA is released.
- R5: After reset, register 0 reads 0x07, register 1 reads 0x66, register 2 and register 3 read 0x00, register 5 reads 0x41 and register 6 reads 0x07.
- R6: Register 4 always reads {revision nibble, 4'b0001}, which is 0x21 with the default revision of 2. Writes to it change nothing, and the index still advances past it.
- R7: Indices 7 and above read as 0x00. Writes to them are acknowledged and change no register.
- R8: Spare bits, meaning register 0 bits 4:3, the unused bits of registers 1 and 2, and all of register 3, store whatever is written.
- R9: The block changes SDA only while SCL is low. It pulls SDA low only in the acknowledge slot of a byte it received, or for a 0 data bit of a byte it sends.
- R10: Output `regs_o` bits [8i+7:8i] always equal register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line as seen on the bus |
| sda_i | input | 1 | SMBus data line as seen on the bus |
| sda_drive_low_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | 8*NUM_REGS | All register contents, register i in bits [8i+7:8i] |

## Verification
Some properties are checked on every cycle. SDA may only move while the resampled SCL is low. The block stays off the line when idle and during the host's acknowledge slot of a read byte. Every stored byte is followed by an acknowledge. A write to an index past the bank leaves all outputs unchanged. Other behaviour shows only in whole bus transactions in the bench: address filtering, the byte order of writes and reads, the count byte taken from register 6, overflow bytes being dropped, the read-only identifier, and the reset contents.

// File: rtl/smb_rb_pkg.sv
`timescale 1ns/1ps
package smb_rb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_INDEX,
      ST_COUNT,
      ST_WDATA,
      ST_RCOUNT,
      ST_RDATA
   } smb_state_e;

   localparam int unsigned BYTE_W  = 8;
   localparam logic [3:0]  BIT_ACK = 4'd8;
   localparam logic [3:0]  BIT_END = 4'd9;

   function automatic logic is_tx(smb_state_e s);
      return (s == ST_RCOUNT) || (s == ST_RDATA);
   endfunction

endpackage

// File: rtl/smb_rb_sync.sv
`timescale 1ns/1ps
module smb_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("smb_rb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_rb_regs.sv
`timescale 1ns/1ps
module smb_rb_regs #(
   parameter int         NUM_REGS      = 7,
   parameter logic [3:0] REV_ID        = 4'h2,
   parameter logic [3:0] VENDOR_ID     = 4'h1,
   parameter logic [7:0] DEVICE_ID_RST = 8'h41,
   parameter logic [7:0] BCNT_RST      = 8'h07
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en_i,
   input  logic [7:0]              wr_idx_i,
   input  logic [7:0]              wr_data_i,
   input  logic [7:0]              rd_idx_i,
   output logic [7:0]              rd_data_o,
   output logic [7:0]              bcnt_o,
   output logic [8*NUM_REGS-1:0]   regs_o
);

   localparam int         RO_IDX   = 4;
   localparam int         BCNT_IDX = 6;
   localparam logic [7:0] LAST_IDX = 8'(NUM_REGS - 1);
   localparam logic [7:0] RO_VAL   = {REV_ID, VENDOR_ID};

   if (NUM_REGS < 7 || NUM_REGS > 256) begin : g_bad_num
      $error("smb_rb_regs: NUM_REGS must lie in 7..256");
   end

   function automatic logic [7:0] rst_val(int i);
      case (i)
         0:        return 8'h07;
         1:        return 8'h66;
         RO_IDX:   return RO_VAL;
         5:        return DEVICE_ID_RST;
         BCNT_IDX: return BCNT_RST;
         default:  return 8'h00;
      endcase
   endfunction

   logic [7:0] q [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) q[i] <= rst_val(i);
      end else if (wr_en_i) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (i != RO_IDX && wr_idx_i == 8'(i)) q[i] <= wr_data_i;
         end
      end
   end

   always_comb begin
      rd_data_o = 8'h00;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_idx_i == 8'(i)) rd_data_o = q[i];
      end
   end

   assign bcnt_o = q[BCNT_IDX];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
      assign regs_o[8*g +: 8] = q[g];
   end

   // R7
   oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_idx_i > LAST_IDX) |=> $stable(regs_o));

   // R6
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_idx_i == 8'(RO_IDX)) |=> $stable(regs_o[8*RO_IDX +: 8]));

endmodule

// File: rtl/smb_rb_fsm.sv
`timescale 1ns/1ps
module smb_rb_fsm
   import smb_rb_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h6E
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_s,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic [7:0] bcnt_i,
   input  logic [7:0] rd_data_i,
   output logic [7:0] idx_o,
   output logic       wr_en_o,
   output logic [7:0] wr_data_o,
   output logic       sda_oe_o
);

   smb_state_e state;
   logic [3:0] bitcnt;
   logic [7:0] rx_sr;
   logic [7:0] tx_byte;
   logic [7:0] idx;
   logic [7:0] wleft;
   logic       rd_mode;
   logic       host_nack;
   logic       ack_slot;
   logic       end_slot;

   assign ack_slot  = scl_fall && (bitcnt == BIT_ACK);
   assign end_slot  = scl_fall && (bitcnt == BIT_END);
   assign wr_en_o   = (state == ST_WDATA) && ack_slot && (wleft != 8'd0);
   assign wr_data_o = rx_sr;
   assign idx_o     = idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         rx_sr     <= '0;
         tx_byte   <= '0;
         idx       <= '0;
         wleft     <= '0;
         rd_mode   <= 1'b0;
         host_nack <= 1'b0;
         sda_oe_o  <= 1'b0;
      end else if (stop_det) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         sda_oe_o <= 1'b0;
      end else if (start_det) begin
         state    <= ST_ADDR;
         bitcnt   <= '0;
         sda_oe_o <= 1'b0;
      end else if (state != ST_IDLE) begin
         if (scl_rise) begin
            if (bitcnt < BIT_ACK) rx_sr <= {rx_sr[6:0], sda_s};
            else                  host_nack <= sda_s;
            if (bitcnt < BIT_END) bitcnt <= bitcnt + 4'd1;
         end else if (ack_slot) begin
            case (state)
               ST_ADDR: begin
                  if (rx_sr[7:1] == DEV_ADDR) begin
                     sda_oe_o <= 1'b1;
                     rd_mode  <= rx_sr[0];
                  end else begin
                     state <= ST_IDLE;
                  end
               end
               ST_INDEX: begin
                  sda_oe_o <= 1'b1;
                  idx      <= rx_sr;
               end
               ST_COUNT: begin
                  sda_oe_o <= 1'b1;
                  wleft    <= rx_sr;
               end
               ST_WDATA: begin
                  sda_oe_o <= 1'b1;
                  if (wleft != 8'd0) begin
                     idx   <= idx + 8'd1;
                     wleft <= wleft - 8'd1;
                  end
               end
               default: sda_oe_o <= 1'b0;
            endcase
         end else if (end_slot) begin
            bitcnt <= '0;
            case (state)
               ST_ADDR: begin
                  if (rd_mode) begin
                     state    <= ST_RCOUNT;
                     tx_byte  <= bcnt_i;
                     sda_oe_o <= ~bcnt_i[7];
                  end else begin
                     state    <= ST_INDEX;
                     sda_oe_o <= 1'b0;
                  end
               end
               ST_INDEX: begin
                  state    <= ST_COUNT;
                  sda_oe_o <= 1'b0;
               end
               ST_COUNT: begin
                  state    <= ST_WDATA;
                  sda_oe_o <= 1'b0;
               end
               ST_WDATA: sda_oe_o <= 1'b0;
               default: begin
                  if (host_nack) begin
                     state    <= ST_IDLE;
                     sda_oe_o <= 1'b0;
                  end else begin
                     state    <= ST_RDATA;
                     tx_byte  <= rd_data_i;
                     idx      <= idx + 8'd1;
                     sda_oe_o <= ~rd_data_i[7];
                  end
               end
            endcase
         end else if (scl_fall && is_tx(state) && bitcnt != 4'd0 && bitcnt < BIT_ACK) begin
            sda_oe_o <= ~tx_byte[3'(4'd7 - bitcnt)];
         end
      end
   end

   // R9
   sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_s);

   // R1
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe_o);

   // R2
   write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> sda_oe_o);

   // R4
   host_ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_tx(state) && bitcnt == BIT_END) |-> !sda_oe_o);

   // R9
   bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= BIT_END);

endmodule

// File: rtl/smb_regbank_slave.sv
`timescale 1ns/1ps
module smb_regbank_slave
   import smb_rb_pkg::*;
#(
   parameter int         NUM_REGS      = 7,
   parameter logic [6:0] DEV_ADDR      = 7'h6E,
   parameter int         SYNC_STAGES   = 2,
   parameter logic [3:0] REV_ID        = 4'h2,
   parameter logic [3:0] VENDOR_ID     = 4'h1,
   parameter logic [7:0] DEVICE_ID_RST = 8'h41,
   parameter logic [7:0] BCNT_RST      = 8'h07
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_drive_low_o,
   output logic [8*NUM_REGS-1:0] regs_o
);

   localparam int REG_BITS = BYTE_W * NUM_REGS;

   if (REG_BITS != 8 * NUM_REGS) begin : g_bad_width
      $error("smb_regbank_slave: register width mismatch");
   end

   logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [7:0] idx, wr_data, rd_data, bcnt;
   logic       wr_en;

   smb_rb_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   smb_rb_fsm #(.DEV_ADDR(DEV_ADDR)) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .bcnt_i    (bcnt),
      .rd_data_i (rd_data),
      .idx_o     (idx),
      .wr_en_o   (wr_en),
      .wr_data_o (wr_data),
      .sda_oe_o  (sda_drive_low_o)
   );

   smb_rb_regs #(
      .NUM_REGS      (NUM_REGS),
      .REV_ID        (REV_ID),
      .VENDOR_ID     (VENDOR_ID),
      .DEVICE_ID_RST (DEVICE_ID_RST),
      .BCNT_RST      (BCNT_RST)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_idx_i  (idx),
      .wr_data_i (wr_data),
      .rd_idx_i  (idx),
      .rd_data_o (rd_data),
      .bcnt_o    (bcnt),
      .regs_o    (regs_o)
   );

endmodule

// File: tb/test_smb_regbank_slave.sv
`timescale 1ns/1ps
module test_smb_regbank_slave;

   localparam int Q = 50;
   localparam logic [7:0] AW = 8'hDC;
   localparam logic [7:0] AR = 8'hDD;
   // rows: {index, data written, expected read-back}
   localparam logic [23:0] VEC [8] = '{
      {8'd0,   8'h9A, 8'h9A},   // R8 reg0 spare bits 4:3
      {8'd1,   8'h99, 8'h99},   // R8 unused enable bits
      {8'd2,   8'h66, 8'h66},
      {8'd3,   8'hC3, 8'hC3},   // R8 spare register
      {8'd4,   8'h00, 8'h21},   // R6 read-only
      {8'd5,   8'h5A, 8'h5A},
      {8'd7,   8'h77, 8'h00},   // R7
      {8'd200, 8'h11, 8'h00}    // R7
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        m_low = 1'b0;
   logic        sda;
   logic        sda_oe;
   logic [55:0] regs;
   logic [7:0]  mdl [7];
   int          n_chk = 0;
   int          n_fail = 0;
   int          viol = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;
   assign sda = ~(m_low | sda_oe);

   smb_regbank_slave i_smb_regbank_slave (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (scl),
      .sda_i           (sda),
      .sda_drive_low_o (sda_oe),
      .regs_o          (regs)
   );

   always @(sda_oe) if (rst_n && scl) viol++;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [55:0] flat();
      logic [55:0] f;
      for (int i = 0; i < 7; i++) f[8*i +: 8] = mdl[i];
      return f;
   endfunction

   task automatic mdl_write(input logic [7:0] i, input logic [7:0] v);
      if (i < 8'd7 && i != 8'd4) mdl[i] = v;
   endtask

   task automatic bus_start();
      m_low = 1'b0; scl = 1'b1; #Q; m_low = 1'b1; #Q; scl = 1'b0; #Q;
   endtask

   task automatic bus_rstart();
      m_low = 1'b0; #Q; scl = 1'b1; #Q; m_low = 1'b1; #Q; scl = 1'b0; #Q;
   endtask

   task automatic bus_stop();
      m_low = 1'b1; #Q; scl = 1'b1; #Q; m_low = 1'b0; #(2*Q);
   endtask

   task automatic tx_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         m_low = ~b[i]; #Q; scl = 1'b1; #Q; scl = 1'b0; #Q;
      end
      m_low = 1'b0; #Q; scl = 1'b1; #(Q/2); ack = ~sda; #(Q/2); scl = 1'b0; #Q;
   endtask

   task automatic rx_byte(input bit nack, output logic [7:0] b);
      m_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         #Q; scl = 1'b1; #(Q/2); b[i] = sda; #(Q/2); scl = 1'b0;
      end
      #(Q/2); m_low = ~nack; #Q; scl = 1'b1; #Q; scl = 1'b0; #(Q/2); m_low = 1'b0;
   endtask

   task automatic blk_write(input logic [7:0] abyte, input logic [7:0] idx,
                            input logic [7:0] cnt, input logic [31:0] data,
                            input int n, output int nacks);
      bit a;
      nacks = 0;
      bus_start();
      tx_byte(abyte, a); if (!a) nacks++;
      tx_byte(idx, a);   if (!a) nacks++;
      tx_byte(cnt, a);   if (!a) nacks++;
      for (int k = 0; k < n; k++) begin
         tx_byte(data[8*k +: 8], a); if (!a) nacks++;
      end
      bus_stop();
   endtask

   task automatic blk_read(input logic [7:0] idx, input int n, output logic [7:0] cnt_b,
                           output logic [63:0] data, output int nacks, output logic oe_end);
      bit a;
      logic [7:0] b;
      nacks = 0;
      data = '0;
      bus_start();
      tx_byte(AW, a);  if (!a) nacks++;
      tx_byte(idx, a); if (!a) nacks++;
      bus_rstart();
      tx_byte(AR, a);  if (!a) nacks++;
      rx_byte(1'b0, cnt_b);
      for (int k = 0; k < n; k++) begin
         rx_byte(k == n - 1, b);
         data[8*k +: 8] = b;
      end
      #Q; oe_end = sda_oe;
      bus_stop();
   endtask

   initial begin
      #(150000 * 10);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int nk;
      logic [7:0] cb;
      logic [63:0] rd;
      logic oe;
      mdl[0] = 8'h07; mdl[1] = 8'h66; mdl[2] = 8'h00; mdl[3] = 8'h00;
      mdl[4] = 8'h21; mdl[5] = 8'h41; mdl[6] = 8'h07;
      #(10*Q);
      rst_n = 1'b1;
      #(4*Q);
      // R5 R10 reset contents, R9 bus released
      chk("R5 reset contents", 64'(regs), 64'(flat()));
      chk("R9 released after reset", 64'(sda_oe), 64'd0);

      for (int k = 0; k < 8; k++) begin
         blk_write(AW, VEC[k][23:16], 8'd1, 32'(VEC[k][15:8]), 1, nk);
         mdl_write(VEC[k][23:16], VEC[k][15:8]);
         chk("R2 table write acks", 64'(nk), 64'd0);
         blk_read(VEC[k][23:16], 1, cb, rd, nk, oe);
         chk("R4 table count byte", 64'(cb), 64'(mdl[6]));
         chk("R2 table read-back", rd, 64'(VEC[k][7:0]));
         chk("R10 table regs_o", 64'(regs), 64'(flat()));
      end

      // R3 overflow byte acked and dropped
      blk_write(AW, 8'd1, 8'd2, 32'h00EE2211, 3, nk);
      mdl_write(8'd1, 8'h11); mdl_write(8'd2, 8'h22);
      chk("R3 overflow acked", 64'(nk), 64'd0);
      chk("R3 overflow dropped", 64'(regs), 64'(flat()));

      // R1 foreign address ignored
      blk_write(8'hA0, 8'd0, 8'd1, 32'h000000FF, 1, nk);
      chk("R1 foreign address unacked", 64'(nk), 64'd4);
      chk("R1 foreign write ignored", 64'(regs), 64'(flat()));

      // R6 write across read-only register
      blk_write(AW, 8'd3, 8'd3, 32'h00CCBBAA, 3, nk);
      mdl_write(8'd3, 8'hAA); mdl_write(8'd4, 8'hBB); mdl_write(8'd5, 8'hCC);
      chk("R6 write acks", 64'(nk), 64'd0);
      chk("R6 read-only kept", 64'(regs[39:32]), 64'h21);
      chk("R6 neighbours written", 64'(regs), 64'(flat()));

      // R4 multi-byte read from 0
      blk_read(8'd0, 5, cb, rd, nk, oe);
      chk("R4 read acks", 64'(nk), 64'd0);
      chk("R4 count byte", 64'(cb), 64'h07);
      chk("R4 data order", rd, {24'd0, mdl[4], mdl[3], mdl[2], mdl[1], mdl[0]});
      chk("R4 released after NACK", 64'(oe), 64'd0);

      // R7 read across end of bank
      blk_read(8'd5, 4, cb, rd, nk, oe);
      chk("R7 read past end", rd, {32'd0, 8'h00, 8'h00, mdl[6], mdl[5]});

      // R4 count byte follows register 6
      blk_write(AW, 8'd6, 8'd1, 32'h00000003, 1, nk);
      mdl_write(8'd6, 8'h03);
      blk_read(8'd1, 2, cb, rd, nk, oe);
      chk("R4 programmed count", 64'(cb), 64'h03);
      chk("R4 data after count", rd, {48'd0, mdl[2], mdl[1]});
      chk("R10 final regs_o", 64'(regs), 64'(flat()));

      // R9 SDA never moved with SCL high
      chk("R9 SDA change while SCL high", 64'(viol), 64'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule